// File: doc/BRIEF.md
# Socket Interrupt Flag and Mask Controller

This block gathers interrupt events from a card socket and holds each one as a sticky status flag that a host reads through a small register port. There are three groups of sources. Legacy status-change events and socket status-change events each have a host-writable mask. Functional card interrupts have no mask and always reach their output.

Legacy flags are cleared in one of two ways, picked at run time by bit 2 of a control register. They are cleared either by reading the flag register or by writing 1 to a flag bit. After reset, clear-on-read is in force. Socket flags are cleared only by writing 1. The unmasked status-change flags of both banks are ORed onto one level output. The functional interrupts drive a second, separate level output.

Register map (the address is `addr_i`; bits above a bank's width read 0):

- 0: legacy flags
- 1: legacy mask
- 2: socket flags
- 3: socket mask
- 4: control
- 5: functional flags
- 6 and 7: unused

Top module: `sock_irq_ctrl`

## Requirements
- R1: After reset, every flag, mask and control register reads 0, and both `csc_irq_o` and `func_irq_o` are low.
- R2: A high bit on `leg_evt_i` or `skt_evt_i` sets the matching flag at the next clock edge. The flag then stays set until a clear operation removes it.
- R3: When control bit 2 is 0 (clear-on-read), a cycle with `rd_i` high at address 0 returns the current legacy flags on `rdata_o`. Those flags are cleared at that edge. In this mode, writes to address 0 have no effect.
- R4: When control bit 2 is 1 (write-1-to-clear), writing address 0 clears each legacy flag whose `wdata_i` bit is 1. A 0 bit leaves its flag unchanged. In this mode, reads do not clear.
- R5: Socket flags (address 2) are cleared only by writing 1 to the flag bit, whatever the mode. A read never clears them.
- R6: If an event arrives in the same cycle as a clear of its flag, by write or by read, the flag stays set.
- R7: A mask bit set to 1 (addresses 1 and 3) stops that source from driving `csc_irq_o`. Its flag is still set and still readable.
- R8: `csc_irq_o` is high exactly when some legacy or socket flag is set and its mask bit is 0.
- R9: The functional flags (address 5) show `func_evt_i` as sampled at the previous edge. `func_irq_o` is high when any of these flags is set. No mask bit affects them, and writes to address 5 have no effect.
- R10: The masks and control bit 2 read back as written. Mask bits above the bank width read 0, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| leg_evt_i | input | N_LEG | Legacy status-change event pulses |
| skt_evt_i | input | N_SKT | Socket status-change event pulses |
| func_evt_i | input | N_FUNC | Functional card interrupt levels |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rd_i | input | 1 | Read strobe (clears legacy flags in clear-on-read mode) |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| csc_irq_o | output | 1 | Status-change interrupt level |
| func_irq_o | output | 1 | Functional interrupt level |

## Verification
The bench first goes after the mode switch. A design that ignored control bit 2 would clear on a read in write-1-to-clear mode, or would accept writes in clear-on-read mode. Both show up as a wrong flag readback. It then drives an event in the same cycle as a write clear, and again in the same cycle as a read clear. A design that gave the clear priority would drop the event and read 0. Masking is checked with the flags still set, so a mask that also blocked the flag, or that left the output unblocked, is caught. Writes with 0 bits, a write to the functional flags, and the unused addresses confirm that nothing changes where nothing should.

// File: rtl/sock_irq_pkg.sv
package sock_irq_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_LEG_FLAG  = 3'd0;
  localparam logic [AW-1:0] A_LEG_MASK  = 3'd1;
  localparam logic [AW-1:0] A_SKT_FLAG  = 3'd2;
  localparam logic [AW-1:0] A_SKT_MASK  = 3'd3;
  localparam logic [AW-1:0] A_CTRL      = 3'd4;
  localparam logic [AW-1:0] A_FUNC_FLAG = 3'd5;
  localparam int unsigned MODE_BIT = 2;  // 1: write-1-to-clear, 0: clear-on-read
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         w1c_en_i,
  input  logic [N-1:0] w1c_bits_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] clr;

  always_comb begin
    clr = '0;
    if (w1c_en_i) clr = clr | w1c_bits_i;
    if (rd_clr_i) clr = clr | flag_o;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr) | evt_i;
  end

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((flag_o & $past(evt_i)) == $past(evt_i)));

  assert_no_clr_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(w1c_en_i) && !$past(rd_clr_i))
      |-> ((flag_o & $past(flag_o)) == $past(flag_o)));

  assert_zero_bits_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(w1c_en_i) && !$past(rd_clr_i))
      |-> ((~flag_o & $past(flag_o) & ~$past(w1c_bits_i)) == '0));

  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rd_clr_i)) |-> ((flag_o & ~$past(evt_i)) == '0));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import sock_irq_pkg::*;
#(
  parameter int unsigned N_LEG = 4,
  parameter int unsigned N_SKT = 4,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [N_LEG-1:0] leg_mask_o,
  output logic [N_SKT-1:0] skt_mask_o,
  output logic             w1c_mode_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      leg_mask_o <= '0;
      skt_mask_o <= '0;
      w1c_mode_o <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        A_LEG_MASK: leg_mask_o <= wdata_i[N_LEG-1:0];
        A_SKT_MASK: skt_mask_o <= wdata_i[N_SKT-1:0];
        A_CTRL:     w1c_mode_o <= wdata_i[MODE_BIT];
        default: ;
      endcase
    end
  end

  assert_mode_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !($past(wr_i) && $past(addr_i) == A_CTRL)) |-> $stable(w1c_mode_o));
endmodule

// File: rtl/sock_irq_ctrl.sv
module sock_irq_ctrl
  import sock_irq_pkg::*;
#(
  parameter int unsigned N_LEG  = 4,
  parameter int unsigned N_SKT  = 4,
  parameter int unsigned N_FUNC = 2,
  parameter int unsigned DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LEG-1:0]  leg_evt_i,
  input  logic [N_SKT-1:0]  skt_evt_i,
  input  logic [N_FUNC-1:0] func_evt_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              rd_i,
  output logic [DW-1:0]     rdata_o,
  output logic              csc_irq_o,
  output logic              func_irq_o
);
  logic [N_LEG-1:0]  leg_flag, leg_mask;
  logic [N_SKT-1:0]  skt_flag, skt_mask;
  logic [N_FUNC-1:0] func_flag;
  logic              w1c_mode;
  logic              leg_w1c, leg_rdclr, skt_w1c;

  assign leg_w1c   = wr_i && (addr_i == A_LEG_FLAG) && w1c_mode;
  assign leg_rdclr = rd_i && (addr_i == A_LEG_FLAG) && !w1c_mode;
  assign skt_w1c   = wr_i && (addr_i == A_SKT_FLAG);

  irq_ctrl_regs #(.N_LEG(N_LEG), .N_SKT(N_SKT), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .leg_mask_o(leg_mask), .skt_mask_o(skt_mask), .w1c_mode_o(w1c_mode)
  );

  irq_flag_bank #(.N(N_LEG)) u_leg (
    .clk_i, .rst_ni, .evt_i(leg_evt_i), .w1c_en_i(leg_w1c),
    .w1c_bits_i(wdata_i[N_LEG-1:0]), .rd_clr_i(leg_rdclr), .flag_o(leg_flag)
  );

  irq_flag_bank #(.N(N_SKT)) u_skt (
    .clk_i, .rst_ni, .evt_i(skt_evt_i), .w1c_en_i(skt_w1c),
    .w1c_bits_i(wdata_i[N_SKT-1:0]), .rd_clr_i(1'b0), .flag_o(skt_flag)
  );

  // functional interrupts: sampled level, never masked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) func_flag <= '0;
    else         func_flag <= func_evt_i;
  end

  assign csc_irq_o  = |(leg_flag & ~leg_mask) | |(skt_flag & ~skt_mask);
  assign func_irq_o = |func_flag;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_LEG_FLAG:  rdata_o[N_LEG-1:0]  = leg_flag;
      A_LEG_MASK:  rdata_o[N_LEG-1:0]  = leg_mask;
      A_SKT_FLAG:  rdata_o[N_SKT-1:0]  = skt_flag;
      A_SKT_MASK:  rdata_o[N_SKT-1:0]  = skt_mask;
      A_CTRL:      rdata_o[MODE_BIT]   = w1c_mode;
      A_FUNC_FLAG: rdata_o[N_FUNC-1:0] = func_flag;
      default: ;
    endcase
  end

  assert_full_mask_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&leg_mask && &skt_mask) |-> !csc_irq_o);

  assert_func_unmasked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && |$past(func_evt_i)) |-> func_irq_o);

  assert_skt_read_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(skt_w1c)) |-> ((skt_flag & $past(skt_flag)) == $past(skt_flag)));

  assert_evt_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && |($past(leg_evt_i) & ~leg_mask)) |-> csc_irq_o);
endmodule

// File: tb/sock_irq_ctrl_tb.sv
module sock_irq_ctrl_tb;
  localparam int unsigned NL = 4, NS = 4, NF = 2, DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] leg_evt = '0;
  logic [NS-1:0] skt_evt = '0;
  logic [NF-1:0] func_evt = '0;
  logic [2:0]    addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          csc_irq, func_irq;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  sock_irq_ctrl #(.N_LEG(NL), .N_SKT(NS), .N_FUNC(NF), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .leg_evt_i(leg_evt), .skt_evt_i(skt_evt),
    .func_evt_i(func_evt), .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(rdata), .csc_irq_o(csc_irq), .func_irq_o(func_irq)
  );

  typedef struct packed {
    logic          we;
    logic          re;
    logic [2:0]    ad;
    logic [DW-1:0] wd;
    logic [NL-1:0] le;
    logic [NS-1:0] se;
    logic [NF-1:0] fe;
    logic [2:0]    ca;
    logic [DW-1:0] ed;
    logic          ec;
    logic          ef;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,3'd0,8'h00,4'b0101,4'b0000,2'b00,3'd0,8'h05,1'b1,1'b0,8'd2},
    '{1'b1,1'b0,3'd0,8'h05,4'b0000,4'b0000,2'b00,3'd0,8'h05,1'b1,1'b0,8'd3},
    '{1'b0,1'b1,3'd0,8'h00,4'b0000,4'b0000,2'b00,3'd0,8'h00,1'b0,1'b0,8'd3},
    '{1'b0,1'b0,3'd0,8'h00,4'b0000,4'b0010,2'b00,3'd2,8'h02,1'b1,1'b0,8'd8},
    '{1'b0,1'b1,3'd2,8'h00,4'b0000,4'b0000,2'b00,3'd2,8'h02,1'b1,1'b0,8'd5},
    '{1'b1,1'b0,3'd3,8'h02,4'b0000,4'b0000,2'b00,3'd2,8'h02,1'b0,1'b0,8'd7},
    '{1'b1,1'b0,3'd2,8'h02,4'b0000,4'b0000,2'b00,3'd2,8'h00,1'b0,1'b0,8'd5},
    '{1'b1,1'b0,3'd3,8'h00,4'b0000,4'b0000,2'b00,3'd3,8'h00,1'b0,1'b0,8'd10},
    '{1'b1,1'b0,3'd4,8'h04,4'b0000,4'b0000,2'b00,3'd4,8'h04,1'b0,1'b0,8'd10},
    '{1'b0,1'b0,3'd0,8'h00,4'b1000,4'b0000,2'b00,3'd0,8'h08,1'b1,1'b0,8'd8},
    '{1'b0,1'b1,3'd0,8'h00,4'b0000,4'b0000,2'b00,3'd0,8'h08,1'b1,1'b0,8'd4},
    '{1'b1,1'b0,3'd0,8'h00,4'b0000,4'b0000,2'b00,3'd0,8'h08,1'b1,1'b0,8'd4},
    '{1'b1,1'b0,3'd0,8'h08,4'b0000,4'b0000,2'b00,3'd0,8'h00,1'b0,1'b0,8'd4},
    '{1'b0,1'b0,3'd0,8'h00,4'b0000,4'b0000,2'b10,3'd5,8'h02,1'b0,1'b1,8'd9},
    '{1'b1,1'b0,3'd1,8'hFF,4'b0000,4'b0000,2'b10,3'd1,8'h0F,1'b0,1'b1,8'd9},
    '{1'b0,1'b0,3'd0,8'h00,4'b0000,4'b0000,2'b00,3'd5,8'h00,1'b0,1'b0,8'd9},
    '{1'b1,1'b0,3'd5,8'hFF,4'b0000,4'b0000,2'b00,3'd5,8'h00,1'b0,1'b0,8'd9},
    '{1'b0,1'b0,3'd0,8'h00,4'b0001,4'b0000,2'b00,3'd0,8'h01,1'b0,1'b0,8'd7}
  };

  task automatic check(input string what, input int req,
                       input logic [DW-1:0] d, input logic c, input logic f);
    n_run++;
    if (rdata !== d || csc_irq !== c || func_irq !== f) begin
      n_fail++;
      $display("FAIL R%0d %s: got rdata=%h csc=%b func=%b, expected rdata=%h csc=%b func=%b",
               req, what, rdata, csc_irq, func_irq, d, c, f);
    end
  endtask

  // one access cycle, then inputs return to idle and addr points at the check register
  task automatic step(input logic w, input logic r, input logic [2:0] a, input logic [DW-1:0] d,
                      input logic [NL-1:0] l, input logic [NS-1:0] s, input logic [NF-1:0] fv,
                      input logic [2:0] ca);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; leg_evt = l; skt_evt = s; func_evt = fv;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; wdata = '0; leg_evt = '0; skt_evt = '0; addr = ca;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got running, expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      addr = 3'(a); #1;
      check("reset readback", 1, 8'h00, 1'b0, 1'b0);
    end
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      step(VEC[i].we, VEC[i].re, VEC[i].ad, VEC[i].wd, VEC[i].le, VEC[i].se, VEC[i].fe, VEC[i].ca);
      func_evt = '0;
      check($sformatf("vector %0d", i), int'(VEC[i].req), VEC[i].ed, VEC[i].ec, VEC[i].ef);
    end

    // now: W1C mode, legacy flag 01 set, legacy mask 0F
    // R6: write-1 clear coincides with event
    step(1'b1, 1'b0, 3'd0, 8'h01, 4'b0001, '0, '0, 3'd0);
    check("w1c vs event", 6, 8'h01, 1'b0, 1'b0);
    // back to clear-on-read, unmask
    step(1'b1, 1'b0, 3'd4, 8'h00, '0, '0, '0, 3'd0);
    step(1'b1, 1'b0, 3'd1, 8'h00, '0, '0, '0, 3'd0);
    check("unmask shows flag R8", 8, 8'h01, 1'b1, 1'b0);
    // R3: read strobe returns flags in the read cycle
    @(negedge clk);
    rd = 1'b1; addr = 3'd0; leg_evt = 4'b0001; #1;
    check("read data in strobe cycle R3", 3, 8'h01, 1'b1, 1'b0);
    @(negedge clk);
    rd = 1'b0; leg_evt = '0; #1;
    check("read clear vs event", 6, 8'h01, 1'b1, 1'b0);
    step(1'b0, 1'b1, 3'd0, '0, '0, '0, '0, 3'd0);
    check("plain read clears", 3, 8'h00, 1'b0, 1'b0);
    // R10: unused addresses
    step(1'b1, 1'b0, 3'd6, 8'hFF, '0, '0, '0, 3'd6);
    check("addr 6 reads zero", 10, 8'h00, 1'b0, 1'b0);
    addr = 3'd7; #1;
    check("addr 7 reads zero", 10, 8'h00, 1'b0, 1'b0);
    addr = 3'd4; #1;
    check("ctrl only bit 2 R10", 10, 8'h00, 1'b0, 1'b0);
    // R2: flag persists several idle cycles
    step(1'b0, 1'b0, 3'd0, '0, '0, 4'b1000, '0, 3'd2);
    repeat (4) @(negedge clk);
    #1;
    check("socket flag persists", 2, 8'h08, 1'b1, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule